// File: doc/BRIEF.md
# Legacy Keyboard Port Trap and SMI Router

This block holds a 16-bit legacy-support control and status word for a USB host controller. It watches a simple I/O bus for reads and writes to the two keyboard-controller ports, 60h and 64h. Every matching access sets a sticky flag. Each kind of access has its own enable that lets its flag pull the active-low system-management interrupt (`smi_n`). The same word decides whether the host controller's USB interrupt goes to the ordinary PCI interrupt line, to `smi_n`, to both or to neither. It also tracks a small A20 passthrough status path: an in-progress indication, and a sticky "sequence ended" flag that can also raise `smi_n`.

Firmware and the operating-system driver reach the word through a one-cycle register write strobe and a combinational read port. Firmware takes the controller by setting the USB-to-SMI enable. The driver takes it back by writing 0x2000, which leaves only the interrupt-line routing on. Keyboard data emulation and PCI configuration decoding are outside the block.

Top module: `kts_legacy_router`

## Requirements
- R1: After a synchronous reset the word reads 0x2000. Bit 13 (interrupt-line routing) is 1, and every other bit is 0 while `usb_irq` and `a20_busy` are low.
- R2: The flag sets on the clock edge where `io_addr` equals the port exactly and the strobe is high. The flags are: bit 8 for a port 60h read, bit 9 for a port 60h write, bit 10 for a port 64h read and bit 11 for a port 64h write. An access to any other address changes no flag.
- R3: Writing 1 to a flag bit (8 to 11 or 15) clears it, and writing 0 leaves it as it is. When a clear and a new setting event arrive in the same cycle, the flag stays set.
- R4: `smi_n` is low while any flag bit 8+i is set and its enable bit i is also set (i = 0 for a 60h read, 1 for a 60h write, 2 for a 64h read, 3 for a 64h write). A flag whose enable is 0 does not drive `smi_n`.
- R5: With bit 4 set, `smi_n` is low whenever `usb_irq` is high. With bit 4 clear, `usb_irq` has no effect on `smi_n`.
- R6: `usb_intr` equals `usb_irq` while bit 13 is 1, and stays 0 while bit 13 is 0.
- R7: Bit 12 is read-only and reads the current level of `usb_irq`.
- R8: Bit 6 reads 1 while bit 5 is 1 and `a20_busy` is high. Bit 15 sets on the first clock edge after bit 6 goes from 1 to 0, and `a20_busy` has no effect while bit 5 is 0. With bit 7 set, bit 15 drives `smi_n` low.
- R9: Bits 0 to 5, 7 and 13 read back the last value written to them. Bit 14 always reads 0. Writing 0x2000 leaves routing on and both SMI enables off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Address on the observed I/O bus |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register contents |
| usb_irq | input | 1 | Host controller USB interrupt request |
| a20_busy | input | 1 | A20 passthrough sequence is running |
| usb_intr | output | 1 | USB interrupt routed to the PCI interrupt line |
| smi_n | output | 1 | Active-low system-management interrupt |

## Verification
The bench sweeps addresses around both ports with each kind of strobe, so a partial address compare or a swapped flag position shows up as a wrong bit or an extra bit. It tries all sixteen trap enable patterns against a full set of flags, which catches an SMI term wired to the wrong enable or left ungated. The bench also puts a clear and a trap event in the same cycle: a design that gives the clear priority would lose the event. The A20 tests check that the end flag appears one edge after the sequence stops, and that a sequence running while its enable is off leaves no trace.

// File: rtl/kts_pkg.sv
package kts_pkg;

    localparam int NTRAP = 4;

    // Field layout of the legacy-support word, MSB first.
    typedef struct packed {
        logic             a20_done;
        logic             rsvd;
        logic             route_en;
        logic             irq_live;
        logic [NTRAP-1:0] trap_flag;
        logic             a20_smi_en;
        logic             a20_prog;
        logic             a20_en;
        logic             usb_smi_en;
        logic [NTRAP-1:0] trap_en;
    } legsup_t;

    localparam logic [15:0] LEGSUP_RESET = 16'h2000;

    // Channels 0/1 watch the data port, 2/3 the command port;
    // even channels trap reads, odd channels trap writes.
    function automatic bit chan_is_cmd(int idx);
        return idx >= 2;
    endfunction

    function automatic bit chan_is_write(int idx);
        return (idx % 2) == 1;
    endfunction

    function automatic logic smi_request(legsup_t w, logic irq);
        return (|(w.trap_flag & w.trap_en))
             | (irq & w.usb_smi_en)
             | (w.a20_done & w.a20_smi_en);
    endfunction

endpackage

// File: rtl/kts_trap_chan.sv
module kts_trap_chan #(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] MATCH    = 'h60,
    parameter bit            WR_KIND  = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic          clr,
    output logic          flag
);

    logic hit;

    always_comb begin
        hit = (io_addr == MATCH) && (WR_KIND ? io_wr : io_rd);
    end

    // A fresh event outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assert_trap_sets_R2: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag);
    assert_flag_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hit) |=> $stable(flag));

endmodule

// File: rtl/kts_a20_track.sv
module kts_a20_track (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic busy_in,
    input  logic clr,
    output logic prog,
    output logic done
);

    logic prog_q;
    logic ended;

    always_comb begin
        prog  = en & busy_in;
        ended = prog_q & ~prog;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            prog_q <= prog;
            if (ended)    done <= 1'b1;
            else if (clr) done <= 1'b0;
        end
    end

    assert_a20_end_sets_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(prog) |=> done);

endmodule

// File: rtl/kts_legacy_router.sv
module kts_legacy_router #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] DATA_PORT = 'h60,
    parameter logic [AW-1:0] CMD_PORT  = 'h64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic          reg_wr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          usb_irq,
    input  logic          a20_busy,
    output logic          usb_intr,
    output logic          smi_n
);
    import kts_pkg::*;

    legsup_t              wr_word;
    legsup_t              rd_word;
    logic [NTRAP-1:0]     trap_en;
    logic [NTRAP-1:0]     trap_flag;
    logic                 usb_smi_en;
    logic                 a20_en;
    logic                 a20_smi_en;
    logic                 route_en;
    logic                 a20_prog;
    logic                 a20_done;
    logic                 unused_wbits;

    assign wr_word      = legsup_t'(reg_wdata);
    assign unused_wbits = ^{wr_word.rsvd, wr_word.irq_live, wr_word.a20_prog};

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_en    <= '0;
            usb_smi_en <= 1'b0;
            a20_en     <= 1'b0;
            a20_smi_en <= 1'b0;
            route_en   <= LEGSUP_RESET[13];
        end else if (reg_wr) begin
            trap_en    <= wr_word.trap_en;
            usb_smi_en <= wr_word.usb_smi_en;
            a20_en     <= wr_word.a20_en;
            a20_smi_en <= wr_word.a20_smi_en;
            route_en   <= wr_word.route_en;
        end
    end

    for (genvar g = 0; g < NTRAP; g++) begin : g_trap
        localparam logic [AW-1:0] PORT = chan_is_cmd(g) ? CMD_PORT : DATA_PORT;
        localparam bit            WRK  = chan_is_write(g);
        kts_trap_chan #(
            .AW      (AW),
            .MATCH   (PORT),
            .WR_KIND (WRK)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .io_addr (io_addr),
            .io_rd   (io_rd),
            .io_wr   (io_wr),
            .clr     (reg_wr & wr_word.trap_flag[g]),
            .flag    (trap_flag[g])
        );
    end

    kts_a20_track u_a20 (
        .clk     (clk),
        .rst     (rst),
        .en      (a20_en),
        .busy_in (a20_busy),
        .clr     (reg_wr & wr_word.a20_done),
        .prog    (a20_prog),
        .done    (a20_done)
    );

    always_comb begin
        rd_word            = '0;
        rd_word.trap_en    = trap_en;
        rd_word.usb_smi_en = usb_smi_en;
        rd_word.a20_en     = a20_en;
        rd_word.a20_prog   = a20_prog;
        rd_word.a20_smi_en = a20_smi_en;
        rd_word.trap_flag  = trap_flag;
        rd_word.irq_live   = usb_irq;
        rd_word.route_en   = route_en;
        rd_word.rsvd       = 1'b0;
        rd_word.a20_done   = a20_done;
        reg_rdata          = 16'(rd_word);
        usb_intr           = usb_irq & route_en;
        smi_n              = ~smi_request(rd_word, usb_irq);
    end

    assert_smi_on_trap_R4: assert property (@(posedge clk) disable iff (rst)
        ((trap_flag & trap_en) != '0) |-> !smi_n);
    assert_route_off_R6: assert property (@(posedge clk) disable iff (rst)
        !route_en |-> !usb_intr);
    assert_a20_smi_R8: assert property (@(posedge clk) disable iff (rst)
        (a20_done && a20_smi_en) |-> !smi_n);

endmodule

// File: tb/kts_legacy_router_bench.sv
module kts_legacy_router_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_addr;
    logic        io_rd, io_wr, reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        usb_irq, a20_busy;
    logic        usb_intr, smi_n;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #2 clk = ~clk;

    kts_legacy_router u_kts_legacy_router (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .usb_irq(usb_irq), .a20_busy(a20_busy), .usb_intr(usb_intr), .smi_n(smi_n)
    );

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wreg(logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic io_access(logic [15:0] a, bit wr);
        @(negedge clk);
        io_addr = a; io_rd = !wr; io_wr = wr;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0; io_addr = '0;
    endtask

    initial begin
        #400000;
        if (!done_run) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; io_addr = '0; io_rd = 0; io_wr = 0; reg_wr = 0;
        reg_wdata = '0; usb_irq = 0; a20_busy = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", reg_rdata, 16'h2000);
        chk("R1 smi idle", {15'd0, smi_n}, 16'd1);

        // R2: address and strobe sweep
        for (int a = 16'h5C; a <= 16'h68; a++) begin
            for (int k = 0; k < 2; k++) begin
                logic [15:0] expf;
                wreg(16'h2F00);
                io_access(a[15:0], k[0]);
                expf = '0;
                if (a == 16'h60) expf = (k == 1) ? 16'h0200 : 16'h0100;
                if (a == 16'h64) expf = (k == 1) ? 16'h0800 : 16'h0400;
                chk("R2 trap flags", reg_rdata & 16'h0F00, expf);
            end
        end
        // high address bits must also match
        wreg(16'h2F00);
        io_access(16'h0160, 1'b0);
        chk("R2 upper bits differ", reg_rdata & 16'h0F00, 16'h0000);

        // R4: enable sweep with all flags set
        for (int e = 0; e < 16; e++) begin
            io_access(16'h60, 0); io_access(16'h60, 1);
            io_access(16'h64, 0); io_access(16'h64, 1);
            wreg(16'h2000 | 16'(e));
            chk("R4 smi vs enable", {15'd0, smi_n}, (e != 0) ? 16'd0 : 16'd1);
            chk("R9 enable readback", reg_rdata & 16'h0F0F, 16'h0F00 | 16'(e));
        end

        // R3: writing 0 keeps flags, writing 1 clears only chosen bits
        wreg(16'h2000);
        chk("R3 write zero keeps", reg_rdata & 16'h0F00, 16'h0F00);
        wreg(16'h2500);
        chk("R3 partial clear", reg_rdata & 16'h0F00, 16'h0A00);
        wreg(16'h2A00);
        chk("R3 all clear", reg_rdata & 16'h0F00, 16'h0000);
        // same-cycle clear and event
        @(negedge clk);
        reg_wr = 1; reg_wdata = 16'h2200; io_addr = 16'h60; io_wr = 1;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; io_addr = '0; io_wr = 0;
        chk("R3 event beats clear", reg_rdata & 16'h0F00, 16'h0200);
        wreg(16'h2F00);

        // R5, R6, R7: usb irq routing sweep
        for (int m = 0; m < 8; m++) begin
            bit irq, sen, rte;
            irq = m[0]; sen = m[1]; rte = m[2];
            wreg((rte ? 16'h2000 : 16'h0000) | (sen ? 16'h0010 : 16'h0000));
            @(negedge clk); usb_irq = irq;
            #1;
            chk("R5 usb smi", {15'd0, smi_n}, (irq && sen) ? 16'd0 : 16'd1);
            chk("R6 intr line", {15'd0, usb_intr}, (irq && rte) ? 16'd1 : 16'd0);
            chk("R7 irq live bit", {15'd0, reg_rdata[12]}, {15'd0, irq});
            usb_irq = 0;
        end

        // R9: driver handback value and reserved bit
        wreg(16'hFFFF & ~16'h8F00);
        chk("R9 rsvd reads 0", {15'd0, reg_rdata[14]}, 16'd0);
        wreg(16'h2000);
        chk("R9 handback word", reg_rdata, 16'h2000);

        // R8: A20 path
        @(negedge clk); a20_busy = 1;
        @(negedge clk);
        chk("R8 disabled prog", reg_rdata & 16'h8040, 16'h0000);
        a20_busy = 0;
        @(negedge clk); @(negedge clk);
        chk("R8 disabled no end", reg_rdata & 16'h8040, 16'h0000);
        wreg(16'h2020);
        @(negedge clk); a20_busy = 1;
        repeat (3) @(negedge clk);
        chk("R8 in progress", reg_rdata & 16'h8040, 16'h0040);
        a20_busy = 0;
        #1;
        chk("R8 prog drops", reg_rdata & 16'h8040, 16'h0000);
        @(negedge clk);
        chk("R8 end flag", reg_rdata & 16'h8040, 16'h8000);
        chk("R8 smi masked", {15'd0, smi_n}, 16'd1);
        wreg(16'h20A0);
        chk("R8 smi on end", {15'd0, smi_n}, 16'd0);
        wreg(16'hA0A0);
        chk("R3 end flag w1c", reg_rdata & 16'h8000, 16'h0000);
        chk("R8 smi released", {15'd0, smi_n}, 16'd1);

        done_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule